// File: doc/BRIEF.md
# Dual Timer/Counter with Four Counting Modes

This block holds two identical 16-bit timer/counter channels, each built from a low byte and a high byte. A shared configuration byte gives every channel a gating enable, a source select (internal machine-cycle ticks or falling edges on an external count pin) and a two-bit counting mode. A control byte holds one run bit and one overflow flag per channel. Software reaches all registers over a small byte-wide bus, and reads are combinational.

The four modes are a 13-bit counter, a plain 16-bit counter, an 8-bit counter that reloads from the high byte, and a split mode. In split mode channel 0 becomes two independent 8-bit counters, and its high half borrows channel 1's run bit and overflow flag. Overflow flags go to an external interrupt controller, which pulses an acknowledge input when it vectors the interrupt. Every overflow of channel 1 also produces a one-clock pulse that can drive a serial baud generator. The external pins pass through synchronisers inside the block.

Top module: `dual_timer_counter`

## Requirements
- R1: Bus writes at address 0 (configuration: channel 0 in bits 3:0, channel 1 in bits 7:4, each nibble being gate bit 3, source bit 2, mode bits 1:0), address 2/3 (channel 0 low/high) and address 4/5 (channel 1 low/high) update the register on the next clock edge, and reading the same address returns it.
- R2: With the source bit at 0 and its run bit set, a channel advances once per clock in which `tick` is high. With the run bit clear it holds. Control byte at address 1 is bit 7 flag 1, bit 6 run 1, bit 5 flag 0, bit 4 run 0, bits 3:0 read as zero.
- R3: With the gate bit set, a channel advances only while its synchronised gate pin is high.
- R4: With the source bit at 1, the count pin is sampled on each `tick` after a two-stage synchroniser, and the channel advances once for each sample of 0 that follows a sample of 1.
- R5: Mode 0 counts the 13-bit value {high[4:0], low[7:0]}. High bits 7:5 are untouched, and the wrap from 0x1FFF to 0 sets the flag.
- R6: Mode 1 counts {high, low} as 16 bits. The wrap from 0xFFFF to 0x0000 sets the flag, and the value continues from zero.
- R7: Mode 2 counts the low byte only. A count at 0xFF loads the low byte from the high byte and sets the flag.
- R8: When channel 0 is in mode 3, its low byte is an 8-bit counter under channel 0's controls that sets flag 0 on wrap. Its high byte counts every `tick` while run bit 1 is set, and sets flag 1 on wrap.
- R9: While channel 0 is in mode 3, channel 1 ignores run bit 1, never sets flag 1 and still produces baud pulses. Channel 1 in mode 3 holds its value.
- R10: An acknowledge pulse clears the channel's flag on the next edge. A hardware set in the same cycle wins, and a control-byte write in the same cycle loads the written bit.
- R11: A bus write to a counter byte takes priority over a count of that byte in the same cycle.
- R12: `baud_tick` is high for exactly the clock after each channel 1 overflow, in every mode and whichever flag that overflow does or does not set.
- R13: After reset every register, flag, run bit and output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Machine-cycle enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| cnt_pin | input | 2 | Asynchronous external event pins, one per channel |
| gate_pin | input | 2 | Asynchronous gate pins, one per channel |
| irq_ack | input | 2 | Interrupt vectored acknowledge, one per channel |
| ovf_flag | output | 2 | Overflow flags, bit n for channel n |
| baud_tick | output | 1 | One-clock pulse per channel 1 overflow |

## Verification
The bench targets the wraps of each mode. A 13-bit counter that leaked into high bits 7:5, or a reload mode that cleared to zero instead of loading the high byte, would show wrong counter bytes on the next read. In split mode it checks that the high half of channel 0 drives flag 1 while channel 1 keeps running and sending baud pulses without touching that flag. A design that left channel 1 wired to its own flag would raise flag 1 with run bit 1 clear. Acknowledge pulses that land on a new overflow, and bus writes that land on a count, check the priority order: a wrong order would lose a flag or keep a stale byte. Counting on the wrong pin edge, or without the synchroniser delay, shifts the counted value by one tick against the reference model.

// File: rtl/dual_timer_counter.sv
module dual_timer_counter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       bus_we,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [1:0] cnt_pin,
  input  logic [1:0] gate_pin,
  input  logic [1:0] irq_ack,
  output logic [1:0] ovf_flag,
  output logic       baud_tick
);

  logic [7:0] mode_q;
  logic [1:0] run_q, flg_q, smp_q;
  logic [7:0] lo_q [2];
  logic [7:0] hi_q [2];
  logic [7:0] lo_d [2];
  logic [7:0] hi_d [2];
  logic [1:0] ovf;
  logic       hi_ovf;
  logic       baud_q;
  logic [SYNC_STAGES-1:0] sync_q [4];

  wire [3:0] pins_in = {gate_pin, cnt_pin};
  wire [1:0] cnt_s   = {sync_q[1][SYNC_STAGES-1], sync_q[0][SYNC_STAGES-1]};
  wire [1:0] gate_s  = {sync_q[3][SYNC_STAGES-1], sync_q[2][SYNC_STAGES-1]};

  wire split   = mode_q[1:0] == 2'd3;
  wire ctrl_we = bus_we && bus_addr == 3'd1;
  wire [1:0] wr_lo = {bus_we && bus_addr == 3'd4, bus_we && bus_addr == 3'd2};
  wire [1:0] wr_hi = {bus_we && bus_addr == 3'd5, bus_we && bus_addr == 3'd3};

  wire [1:0] evt     = {2{tick}} & smp_q & ~cnt_s;
  wire [1:0] run_eff = {split | run_q[1], run_q[0]};
  wire [1:0] gate_ok = ~{mode_q[7], mode_q[3]} | gate_s;
  wire [1:0] src     = {mode_q[6] ? evt[1] : tick, mode_q[2] ? evt[0] : tick};
  wire [1:0] en      = run_eff & gate_ok & src;
  wire       hi_run  = split & tick & run_q[1];
  wire [1:0] set     = {split ? hi_ovf : ovf[1], ovf[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) sync_q[k] <= '0;
    end else begin
      for (int k = 0; k < 4; k++)
        sync_q[k] <= {sync_q[k][SYNC_STAGES-2:0], pins_in[k]};
    end
  end

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      lo_d[c] = lo_q[c];
      hi_d[c] = hi_q[c];
      ovf[c]  = 1'b0;
      if (en[c]) begin
        unique case (mode_q[4*c +: 2])
          2'd0: begin
            {hi_d[c][4:0], lo_d[c]} = {hi_q[c][4:0], lo_q[c]} + 13'd1;
            ovf[c] = &{hi_q[c][4:0], lo_q[c]};
          end
          2'd1: begin
            {hi_d[c], lo_d[c]} = {hi_q[c], lo_q[c]} + 16'd1;
            ovf[c] = &{hi_q[c], lo_q[c]};
          end
          2'd2: begin
            if (&lo_q[c]) begin
              lo_d[c] = hi_q[c];
              ovf[c]  = 1'b1;
            end else begin
              lo_d[c] = lo_q[c] + 8'd1;
            end
          end
          default: begin
            if (c == 0) begin
              lo_d[c] = lo_q[c] + 8'd1;
              ovf[c]  = &lo_q[c];
            end
          end
        endcase
      end
    end
    hi_ovf = hi_run & (&hi_q[0]);
    if (hi_run) hi_d[0] = hi_q[0] + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      flg_q  <= '0;
      smp_q  <= '0;
      baud_q <= 1'b0;
      for (int c = 0; c < 2; c++) begin
        lo_q[c] <= '0;
        hi_q[c] <= '0;
      end
    end else begin
      if (bus_we && bus_addr == 3'd0) mode_q <= bus_wdata;
      if (ctrl_we) run_q <= {bus_wdata[6], bus_wdata[4]};
      flg_q  <= set | (ctrl_we ? {bus_wdata[7], bus_wdata[5]} : (flg_q & ~irq_ack));
      if (tick) smp_q <= cnt_s;
      baud_q <= ovf[1];
      for (int c = 0; c < 2; c++) begin
        lo_q[c] <= wr_lo[c] ? bus_wdata : lo_d[c];
        hi_q[c] <= wr_hi[c] ? bus_wdata : hi_d[c];
      end
    end
  end

  always_comb begin
    unique case (bus_addr)
      3'd0:    bus_rdata = mode_q;
      3'd1:    bus_rdata = {flg_q[1], run_q[1], flg_q[0], run_q[0], 4'h0};
      3'd2:    bus_rdata = lo_q[0];
      3'd3:    bus_rdata = hi_q[0];
      3'd4:    bus_rdata = lo_q[1];
      3'd5:    bus_rdata = hi_q[1];
      default: bus_rdata = 8'h00;
    endcase
  end

  assign ovf_flag  = flg_q;
  assign baud_tick = baud_q;

  a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q[0] && !wr_lo[0]) |=> $stable(lo_q[0]));

  a_r3_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[3] && !gate_s[0] && !split && !wr_lo[0] && !wr_hi[0])
      |=> ($stable(lo_q[0]) && $stable(hi_q[0])));

  a_r5_upper_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'd0 && !wr_hi[0]) |=> $stable(hi_q[0][7:5]));

  a_r9_split_flag1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (split && !run_q[1] && !ctrl_we && !flg_q[1]) |=> !flg_q[1]);

  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack[0] && !ctrl_we && !set[0]) |=> !flg_q[0]);

  a_r12_baud_from_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> ($past(lo_q[1]) == 8'hFF));

endmodule

// File: tb/tb_dual_timer_counter.sv
`timescale 1ns/1ps
module tb_dual_timer_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [1:0] cnt_pin = 2'b00;
  logic [1:0] gate_pin = 2'b00;
  logic [1:0] irq_ack = 2'b00;
  logic [1:0] ovf_flag;
  logic       baud_tick;

  dual_timer_counter dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .irq_ack(irq_ack), .ovf_flag(ovf_flag), .baud_tick(baud_tick)
  );

  always #2.5 clk = ~clk;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R13";
  bit    tick_slow = 0, cnt_tog = 0, gate_tog = 0, ack_on = 0;
  bit    wq_v = 0;
  int    wq_a = 0, wq_d = 0;
  int    cyc = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    tick <= tick_slow ? ~tick : 1'b1;
    if (wq_v) begin
      bus_we <= 1'b1; bus_addr <= 3'(wq_a); bus_wdata <= 8'(wq_d); wq_v = 0;
    end else begin
      bus_we <= 1'b0; bus_addr <= 3'(cyc % 6);
    end
    if (cnt_tog && cyc % 3 == 0) cnt_pin[0] <= ~cnt_pin[0];
    if (cnt_tog && cyc % 4 == 0) cnt_pin[1] <= ~cnt_pin[1];
    if (gate_tog && cyc % 11 == 0) gate_pin <= ~gate_pin;
    irq_ack <= (ack_on && cyc % 9 == 0) ? 2'b11 : 2'b00;
  end

  int m_mode, m_tr[2], m_tf[2], m_lo[2], m_hi[2], m_s1[2], m_s2[2], m_g1[2], m_g2[2], m_smp[2], m_baud;

  always @(posedge clk) begin : model
    int sp, md, ev, run, en, v, ovfh, t;
    int nlo[2], nhi[2], ov[2], st[2];
    if (!rst_n) begin
      m_mode = 0; m_baud = 0;
      for (int c = 0; c < 2; c++) begin
        m_tr[c] = 0; m_tf[c] = 0; m_lo[c] = 0; m_hi[c] = 0;
        m_s1[c] = 0; m_s2[c] = 0; m_g1[c] = 0; m_g2[c] = 0; m_smp[c] = 0;
      end
    end else begin
      sp = ((m_mode & 3) == 3);
      for (int c = 0; c < 2; c++) begin
        md  = (m_mode >> (4 * c)) & 15;
        ev  = tick && m_smp[c] && !m_s2[c];
        run = (c == 1 && sp) ? 1 : m_tr[c];
        en  = run && (((md >> 3) & 1) == 0 || m_g2[c]) && (((md >> 2) & 1) ? ev : tick);
        nlo[c] = m_lo[c]; nhi[c] = m_hi[c]; ov[c] = 0;
        if (en) begin
          case (md & 3)
            0: begin
              v = (m_hi[c] % 32) * 256 + m_lo[c] + 1;
              if (v == 8192) begin v = 0; ov[c] = 1; end
              nlo[c] = v % 256; nhi[c] = (m_hi[c] / 32) * 32 + v / 256;
            end
            1: begin
              v = m_hi[c] * 256 + m_lo[c] + 1;
              if (v == 65536) begin v = 0; ov[c] = 1; end
              nlo[c] = v % 256; nhi[c] = v / 256;
            end
            2: begin
              if (m_lo[c] == 255) begin nlo[c] = m_hi[c]; ov[c] = 1; end
              else nlo[c] = m_lo[c] + 1;
            end
            default: if (c == 0) begin nlo[c] = (m_lo[c] + 1) % 256; ov[c] = (m_lo[c] == 255); end
          endcase
        end
      end
      ovfh = 0;
      if (sp && tick && m_tr[1]) begin
        ovfh = (m_hi[0] == 255); nhi[0] = (m_hi[0] + 1) % 256;
      end
      st[0] = ov[0]; st[1] = sp ? ovfh : ov[1];
      for (int c = 0; c < 2; c++) begin
        if (bus_we && bus_addr == 1) t = (bus_wdata >> (5 + 2 * c)) & 1;
        else if (irq_ack[c]) t = 0;
        else t = m_tf[c];
        m_tf[c] = st[c] | t;
        if (bus_we && bus_addr == 1) m_tr[c] = (bus_wdata >> (4 + 2 * c)) & 1;
        m_lo[c] = (bus_we && bus_addr == 2 + 2 * c) ? int'(bus_wdata) : nlo[c];
        m_hi[c] = (bus_we && bus_addr == 3 + 2 * c) ? int'(bus_wdata) : nhi[c];
        if (tick) m_smp[c] = m_s2[c];
        m_s2[c] = m_s1[c]; m_s1[c] = cnt_pin[c];
        m_g2[c] = m_g1[c]; m_g1[c] = gate_pin[c];
      end
      if (bus_we && bus_addr == 0) m_mode = bus_wdata;
      m_baud = ov[1];
    end
  end

  function automatic int model_rd(int a);
    case (a)
      0: return m_mode;
      1: return m_tf[1] * 128 + m_tr[1] * 64 + m_tf[0] * 32 + m_tr[0] * 16;
      2: return m_lo[0];
      3: return m_hi[0];
      4: return m_lo[1];
      5: return m_hi[1];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    #1;
    chk({cur_req, " flags"}, ovf_flag, m_tf[1] * 2 + m_tf[0]);
    chk({cur_req, " baud"}, baud_tick, m_baud);
    chk({cur_req, " rdata"}, bus_rdata, model_rd(bus_addr));
  end

  task automatic wr(int a, int d);
    @(posedge clk); wq_a = a; wq_d = d; wq_v = 1;
    @(posedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    cur_req = "R13"; idle(8);
    chk("R13 flags after reset", ovf_flag, 0);
    chk("R13 baud after reset", baud_tick, 0);

    cur_req = "R1";
    wr(0, 8'h11); wr(2, 8'h12); wr(3, 8'h34); wr(4, 8'h56); wr(5, 8'h78); idle(8);

    cur_req = "R2";
    wr(1, 8'h10); idle(20); wr(1, 8'h00); idle(6);
    tick_slow = 1; wr(1, 8'h10); idle(20); wr(1, 8'h00); tick_slow = 0; idle(4);

    cur_req = "R6";
    wr(2, 8'hF0); wr(3, 8'hFF); wr(1, 8'h10); idle(30);
    chk("R6 flag0 set after 16-bit wrap", ovf_flag[0], 1);

    cur_req = "R10";
    ack_on = 1; idle(30); ack_on = 0; wr(1, 8'h00); idle(4);

    cur_req = "R5";
    wr(0, 8'h10); wr(2, 8'hF0); wr(3, 8'hFF); wr(1, 8'h10); idle(30);
    chk("R5 flag0 after 13-bit wrap", ovf_flag[0], 1);
    wr(1, 8'h00); idle(4);

    cur_req = "R7";
    tick_slow = 1;
    wr(0, 8'h12); wr(3, 8'hFC); wr(2, 8'hFC); wr(1, 8'h10); idle(40);
    wr(1, 8'h00); tick_slow = 0; idle(4);

    cur_req = "R3";
    wr(0, 8'h19); wr(2, 8'h00); wr(3, 8'h00); wr(1, 8'h10);
    gate_tog = 1; idle(60); gate_tog = 0; gate_pin = 2'b00; idle(10);
    wr(1, 8'h00);

    cur_req = "R4";
    wr(0, 8'h55); wr(1, 8'h50); cnt_tog = 1; idle(50);
    tick_slow = 1; idle(50); tick_slow = 0; cnt_tog = 0; wr(1, 8'h00); idle(4);

    cur_req = "R11";
    wr(0, 8'h11); wr(1, 8'h50); idle(3); wr(2, 8'h40); wr(5, 8'h90); wr(4, 8'h01); idle(5);
    wr(1, 8'h00); idle(4);

    cur_req = "R8";
    wr(0, 8'h13); wr(2, 8'hF8); wr(3, 8'hF0); wr(1, 8'h50); idle(40);
    chk("R8 flag0 from low half", ovf_flag[0], 1);
    chk("R8 flag1 from high half", ovf_flag[1], 1);

    cur_req = "R9";
    wr(1, 8'h10); wr(4, 8'hF0); wr(5, 8'hFF); idle(30);
    chk("R9 flag1 stays clear while split", ovf_flag[1], 0);
    wr(0, 8'h33); idle(20);

    cur_req = "R12";
    wr(0, 8'h20); wr(5, 8'hFB); wr(4, 8'hFB); wr(1, 8'h40); idle(30);
    ack_on = 1; idle(40); ack_on = 0; wr(1, 8'h00); idle(6);

    summary();
  end
endmodule